// File: doc/BRIEF.md
# Serial Memory Slave Interface Front End

This block is the serial side of a memory slave that talks over SPI in clock modes 0 and 3. It runs on the serial clock itself, with an asynchronous reset. Inside each select frame it shifts in whole bytes, most significant bit first. The first byte of a frame is the instruction, and the bytes after it are address or data. Each completed byte goes to the attached core together with a flag that marks the instruction byte. The block also raises a level after a frame ends.

Two instructions are handled locally. One reads the status byte and returns it again and again for as long as the clock runs. The other writes the status byte and updates its three block-protect bits. The write-protect pin can lock those bits.

A hold pin pauses a transfer without ending it. While the pause lasts, the output is released and clock and data are ignored. The transfer then carries on from the bit where it stopped. After reset, the block stays inert until chip select goes from high to low.

The byte stream toward the core is valid-only and has no ready. The serial master cannot be stalled, so the core must take each byte while `rx_valid` is high. That is from the rising clock edge that completes the byte until the next rising edge or until deselect.

Top module: `spi_mem_front`

## Requirements
- R1: `mosi` is sampled on rising `sclk` edges, MSB first. The eighth accepted bit of a byte puts the byte on `rx_data` with `rx_valid` high. `rx_first` is 1 only for the first byte of a frame.
- R2: `miso` changes only on falling `sclk` edges. A bit shifted out is therefore stable at the rising edge where the master samples it.
- R3: While `cs_n` is high, `miso_oe` is 0, meaning the output is high impedance.
- R4: Transfers work the same with the clock idling low (mode 0) and idling high (mode 3).
- R5: After reset, no byte is accepted (`rx_valid` stays 0 and `miso_oe` stays 0) until `cs_n` has had a falling edge. A frame already open at reset release is ignored.
- R6: While the hold pause is active, `miso_oe` is 0 and `sclk` and `mosi` have no effect. After release, the byte continues from the bit where it stopped.
- R7: The pause begins when `hold_n` falls while `sclk` is low. It ends when `hold_n` rises while `sclk` is low. It can exist only while `cs_n` is low.
- R8: Instruction 0x05 makes the block return the status byte MSB first, repeated for every further byte of the frame. The status byte has bits [4:2] set to the protect bits and all other bits at 0.
- R9: Instruction 0x01 followed by a data byte copies data bits [4:2] into the protect bits. This happens at the rising edge that completes the data byte.
- R10: If `wp_n` is 0 at that completing edge, the protect bits keep their value.
- R11: A rising edge on `cs_n` ends the frame and clears the partial bit count. `frame_end` is 1 while the block is deselected, but only if the last frame completed at least one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Received byte is the instruction |
| frame_end | output | 1 | Last frame ended with at least one byte |
| status | output | 8 | Current status byte |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three protect bits at bits 4 to 2, and a byte index that saturates at 3. With these values, each status write can be read back as an exact, asymmetric byte, so bit order and field position are both checked. It also makes the repeated read, a pause in the middle of a byte, and a frame that is already open at reset all reachable within short frames in both clock modes.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPC_WRITE_STAT = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_READ_STAT  = 8'h05;
endpackage

// File: rtl/spi_front_gate.sv
// Arming after the first select edge, and the hold pause latch.
module spi_front_gate (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic hold_n,
  output logic armed,
  output logic paused
);
  // Set by the first falling edge of chip select after reset.
  always_ff @(negedge cs_n or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // The latch is transparent only while the clock is low, so hold
  // transitions take effect only in the low phase.
  always_latch begin
    if (!rst_n || cs_n || !armed) paused = 1'b0;
    else if (!sclk)               paused = !hold_n;
  end
endmodule

// File: rtl/spi_front_rx.sv
module spi_front_rx #(
  parameter int W     = 8,
  parameter int IDX_W = 2
) (
  input  logic             sclk,
  input  logic             frame_rst,
  input  logic             en,
  input  logic             mosi,
  output logic             done_now,
  output logic [W-1:0]     next_byte,
  output logic [IDX_W-1:0] byte_cnt,
  output logic             frame_start,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             rx_first
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0]    LAST_BIT = CW'(W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic [CW-1:0] bit_cnt;
  logic [W-2:0]  sh;

  assign next_byte   = {sh, mosi};
  assign done_now    = en && (bit_cnt == LAST_BIT);
  assign frame_start = en && (bit_cnt == '0) && (byte_cnt == '0);

  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      bit_cnt  <= '0;
      sh       <= '0;
      byte_cnt <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
    end else begin
      rx_valid <= done_now;
      if (en) begin
        sh <= next_byte[W-2:0];
        if (done_now) begin
          bit_cnt  <= '0;
          rx_data  <= next_byte;
          rx_first <= (byte_cnt == '0);
          if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_front_status.sv
module spi_front_status #(
  parameter int W      = 8,
  parameter int BP_W   = 3,
  parameter int BP_LSB = 2
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic         wp_n,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status
);
  logic [BP_W-1:0] bp;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)              bp <= '0;
    else if (wr_fire && wp_n) bp <= wdata[BP_LSB +: BP_W];
  end

  always_comb begin
    status = '0;
    status[BP_LSB +: BP_W] = bp;
  end
endmodule

// File: rtl/spi_front_tx.sv
module spi_front_tx #(
  parameter int W = 8
) (
  input  logic         sclk,
  input  logic         frame_rst,
  input  logic         en,
  input  logic [W-1:0] word,
  output logic         miso
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] TOP = CW'(W - 1);

  logic [CW-1:0] tx_cnt;

  always_ff @(negedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      miso   <= 1'b0;
      tx_cnt <= '0;
    end else if (en) begin
      miso   <= word[TOP - tx_cnt];
      tx_cnt <= tx_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_front_pkg::*;
#(
  parameter int W      = BYTE_W,
  parameter int BP_W   = 3,
  parameter int BP_LSB = 2,
  parameter int IDX_W  = 2
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic         hold_n,
  input  logic         wp_n,
  output logic         miso,
  output logic         miso_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_first,
  output logic         frame_end,
  output logic [W-1:0] status
);
  logic armed, paused, frame_rst, en;
  logic done_now, frame_start, byte_seen, wr_fire, rd_mode;
  logic [W-1:0]     next_byte, op_q;
  logic [IDX_W-1:0] byte_cnt;

  assign frame_rst = !rst_n || cs_n;
  assign en        = armed && !paused;

  spi_front_gate u_gate (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
    .armed(armed), .paused(paused)
  );

  spi_front_rx #(.W(W), .IDX_W(IDX_W)) u_rx (
    .sclk(sclk), .frame_rst(frame_rst), .en(en), .mosi(mosi),
    .done_now(done_now), .next_byte(next_byte), .byte_cnt(byte_cnt),
    .frame_start(frame_start), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_first(rx_first)
  );

  // Instruction register, cleared at every frame boundary.
  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst)                         op_q <= '0;
    else if (done_now && byte_cnt == '0)   op_q <= next_byte;
  end

  assign rd_mode = (op_q == W'(OPC_READ_STAT));
  assign wr_fire = done_now && (byte_cnt == IDX_W'(1)) &&
                   (op_q == W'(OPC_WRITE_STAT));

  spi_front_status #(.W(W), .BP_W(BP_W), .BP_LSB(BP_LSB)) u_stat (
    .sclk(sclk), .rst_n(rst_n), .wr_fire(wr_fire), .wp_n(wp_n),
    .wdata(next_byte), .status(status)
  );

  spi_front_tx #(.W(W)) u_tx (
    .sclk(sclk), .frame_rst(frame_rst), .en(en && rd_mode),
    .word(status), .miso(miso)
  );

  // Survives deselect; cleared by the first accepted edge of a frame.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)           byte_seen <= 1'b0;
    else if (done_now)    byte_seen <= 1'b1;
    else if (frame_start) byte_seen <= 1'b0;
  end

  assign frame_end = cs_n && byte_seen;
  assign miso_oe   = !cs_n && armed && !paused;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       sclk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_oe,
  input logic       paused,
  input logic       armed,
  input logic       rx_valid,
  input logic       wp_n,
  input logic [2:0] bp
);
  // R3
  desel_hiz_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !miso_oe);
  // R6
  hold_hiz_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    paused |-> !miso_oe);
  // R7
  hold_needs_sel_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    paused |-> !cs_n);
  // R5
  unarmed_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !armed |-> !rx_valid);
  // R10
  bp_lock_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (bp != $past(bp)) |-> $past(wp_n));
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
  .paused(paused), .armed(armed), .rx_valid(rx_valid), .wp_n(wp_n),
  .bp(status[4:2])
);

// File: tb/spi_mem_front_test.sv
module spi_mem_front_test;
  localparam int T = 10;
  localparam int H = T / 2;
  localparam int Q = T / 4;

  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_oe, rx_valid, rx_first, frame_end;
  logic [7:0] rx_data, status;
  int n_chk = 0, n_bad = 0;
  bit mode3 = 1'b0;

  spi_mem_front uut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi), .hold_n(hold_n),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .frame_end(frame_end),
    .status(status)
  );

  // {mode3, wp_n, write byte, expected status afterwards}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b1, 8'h1C, 8'h1C},
    {1'b1, 1'b1, 8'h08, 8'h08},
    {1'b0, 1'b0, 8'h14, 8'h08},
    {1'b1, 1'b0, 8'h00, 8'h08},
    {1'b1, 1'b1, 8'hE3, 8'h00},
    {1'b0, 1'b1, 8'h14, 8'h14},
    {1'b0, 1'b1, 8'hFF, 8'h1C},
    {1'b1, 1'b1, 8'h04, 8'h04}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    sclk = 1'b0; #Q; mosi = b; #Q; r = miso; sclk = 1'b1; #H;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  // Byte with a hold pause in the low phase of bit index 4 (fifth bit).
  task automatic byte_hold(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 5; i--) begin
      bit_x(tx[i], r); rx[i] = r;
    end
    sclk = 1'b0; #Q; hold_n = 1'b0; #Q;
    check(miso_oe == 1'b0, "R6 hold hiz", miso_oe, 0);
    for (int k = 0; k < 4; k++) begin
      mosi = ~tx[4]; sclk = 1'b1; #Q; sclk = 1'b0; #Q;
    end
    check(miso_oe == 1'b0, "R7 still paused", miso_oe, 0);
    hold_n = 1'b1; #Q;
    check(miso_oe == 1'b1, "R7 resumed", miso_oe, 1);
    mosi = tx[4]; r = miso; sclk = 1'b1; #H; rx[4] = r;
    for (int i = 3; i >= 0; i--) begin
      bit_x(tx[i], r); rx[i] = r;
    end
  endtask

  task automatic open_frame();
    sclk = mode3; #H; cs_n = 1'b0; #H;
  endtask

  task automatic close_frame();
    if (!mode3) begin sclk = 1'b0; #H; end
    cs_n = 1'b1; #H;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    logic [7:0] rx;
    open_frame();
    byte_x(8'h01, rx);
    check(rx_valid && rx_first && rx_data == 8'h01, "R1 opcode byte", rx_data, 8'h01);
    byte_x(d, rx);
    check(rx_valid && !rx_first && rx_data == d, "R1 data byte", rx_data, d);
    close_frame();
    check(frame_end == 1'b1, "R11 frame_end", frame_end, 1);
  endtask

  task automatic rd_stat(input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    open_frame();
    byte_x(8'h05, rx);
    byte_x(8'h00, rx);
    check(rx == exp, tag, rx, exp);
    byte_x(8'h00, rx);
    check(rx == exp, "R8 repeat", rx, exp);
    close_frame();
    check(miso_oe == 1'b0, "R3 deselected", miso_oe, 0);
  endtask

  initial begin
    #(T * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    // Reset with the frame already open: must be ignored (R5).
    cs_n = 1'b0;
    #(2 * T);
    check(miso_oe == 0 && rx_valid == 0 && frame_end == 0, "R3 reset state", miso_oe, 0);
    rst_n = 1'b1; #H;
    byte_x(8'h01, rx);
    check(rx_valid == 1'b0, "R5 unarmed byte", rx_valid, 0);
    check(miso_oe == 1'b0, "R5 unarmed oe", miso_oe, 0);
    byte_x(8'h1C, rx);
    sclk = 1'b0; #H; cs_n = 1'b1; #H;
    mode3 = 1'b0;
    rd_stat(8'h00, "R5 write ignored");

    // Table walk: write then read back, both modes (R4, R9, R10, R2, R8).
    for (int v = 0; v < 8; v++) begin
      mode3 = VEC[v][17];
      wp_n  = VEC[v][16];
      wr_stat(VEC[v][15:8]);
      wp_n  = 1'b1;
      rd_stat(VEC[v][7:0], "R9 R10 R4 status readback");
      check(status == VEC[v][7:0], "R9 status port", status, VEC[v][7:0]);
    end

    // Hold during a read byte (R6, R2).
    mode3 = 1'b0;
    open_frame();
    byte_x(8'h05, rx);
    byte_hold(8'h00, rx);
    check(rx == 8'h04, "R6 read resumes", rx, 8'h04);
    close_frame();

    // Hold during a write data byte, junk on clock and data ignored (R6).
    mode3 = 1'b1;
    open_frame();
    byte_x(8'h01, rx);
    byte_hold(8'h18, rx);
    check(rx_valid && rx_data == 8'h18, "R6 write byte intact", rx_data, 8'h18);
    close_frame();
    rd_stat(8'h18, "R6 write after hold");

    // Hold low while deselected has no effect once raised (R7).
    mode3 = 1'b0;
    hold_n = 1'b0; #T; hold_n = 1'b1; #H;
    open_frame();
    check(miso_oe == 1'b1, "R7 no pause when deselected", miso_oe, 1);
    close_frame();

    // Partial frame then a fresh frame (R11).
    open_frame();
    for (int i = 0; i < 3; i++) begin
      logic r;
      bit_x(1'b1, r);
    end
    close_frame();
    check(frame_end == 1'b0, "R11 partial frame", frame_end, 0);
    open_frame();
    byte_x(8'h05, rx);
    check(rx_valid && rx_first && rx_data == 8'h05, "R11 count cleared", rx_data, 8'h05);
    close_frame();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule